// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block connects an execution core to a single shared memory bus. When no other transfer is waiting, it reads instruction bytes at consecutive addresses into a small on-chip byte queue. The core then takes bytes from the head of that queue, so it often finds the next instruction byte already on chip instead of waiting for memory. The core can also read the address of the byte at the head of the queue.

When the core takes a jump, call or return, or accepts an interrupt, it asserts a redirect. The queue is emptied and fetching starts again at the new address. If a fetch is still on the bus at that moment, it runs to completion and its byte is thrown away.

Data loads and stores from the core take priority over prefetching. They are granted the bus only between bus cycles. They go past the queue and leave the bytes already queued untouched. The memory side uses a request/ready handshake: the unit holds a transfer on the bus for as many wait states as memory inserts.

Top module: `prefetch_queue_unit`

## Requirements
- R1: The queue never holds more than DEPTH bytes (default 4). A fetch is started only when a slot is free, and a slot is counted as taken for every fetch already on the bus. With the core not consuming, the bus goes idle once the queue is full.
- R2: After reset, and after each redirect, fetches go out at consecutive addresses. They start at RESET_PC, or at the target, and each completed or started fetch adds one to the fetch address.
- R3: `ins_valid` is high exactly when the queue holds a byte. `ins_byte` is the oldest queued byte, which is the memory content at `ins_pc`. A byte is removed on a clock edge where `ins_valid` and `ins_ready` are both high.
- R4: A redirect (`redir_valid`) empties the queue at the next edge, and the next fetch goes to `redir_addr`. If the bus is free at that edge, the fetch starts at that same edge.
- R5: An interrupt acceptance (`irq_take`) flushes the queue in the same way and redirects fetching to `irq_vector`. If both are raised in one cycle, the interrupt vector wins.
- R6: A fetch that is on the bus when a flush occurs finishes its bus cycle, but its byte is not written into the queue.
- R7: A pending data request is granted the bus only at a bus-cycle boundary, never while a fetch is waiting for `mem_ready`. While it is pending, no new fetch starts.
- R8: A data transfer drives `dat_addr`, `dat_we` and `dat_wdata` onto the bus. `dat_done` is high in the cycle the transfer completes, with `dat_rdata` holding the read byte in that cycle. Queued bytes are left unchanged.
- R9: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R10: `ins_pc` resets to RESET_PC and goes up by one on every pop. On a flush it becomes the redirect target or the interrupt vector.
- R11: After a flush, `ins_valid` stays low until the first fetch from the target completes. It rises in the cycle after that completion.
- R12: A bus transfer completes on an edge where `mem_req` and `mem_ready` are both high. A new transfer may start on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | output | 1 | Queue head holds a byte |
| ins_byte | output | 8 | Byte at the queue head |
| ins_pc | output | AW | Address of the byte at the queue head |
| ins_ready | input | 1 | Core pops the head byte |
| redir_valid | input | 1 | Jump, call or return: flush and redirect |
| redir_addr | input | AW | Redirect target address |
| irq_take | input | 1 | Interrupt accepted: flush and redirect |
| irq_vector | input | AW | Interrupt handler address |
| dat_req | input | 1 | Core data access request, held until done |
| dat_we | input | 1 | Data access is a store |
| dat_addr | input | AW | Data access address |
| dat_wdata | input | 8 | Store data |
| dat_done | output | 1 | Data transfer completes this cycle |
| dat_rdata | output | 8 | Load data, valid with dat_done |
| mem_req | output | 1 | Bus transfer request |
| mem_we | output | 1 | Bus transfer is a write |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_rdata | input | 8 | Bus read data |
| mem_ready | input | 1 | Memory completes the transfer this cycle |

## Verification
The bench builds the unit with DEPTH 4, a 16-bit address and a reset address of 0x0100. This depth is shallow enough that a stalled core fills the queue within a handful of cycles. As a result, the full-queue bus idle, read/write pointer wraparound and same-cycle push/pop are all reached many times. The 16-bit address lets redirects near 0xFFFF carry both program counters across the address wrap. Varying the wait-state density lets flushes and data requests arrive both during stalled fetches and at cycle boundaries.

// File: rtl/prefetch_queue_unit.sv
module prefetch_queue_unit #(
  parameter int DEPTH = 4,
  parameter int AW = 16,
  parameter logic [AW-1:0] RESET_PC = 'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          ins_valid,
  output logic [7:0]    ins_byte,
  output logic [AW-1:0] ins_pc,
  input  logic          ins_ready,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_addr,
  input  logic          irq_take,
  input  logic [AW-1:0] irq_vector,
  input  logic          dat_req,
  input  logic          dat_we,
  input  logic [AW-1:0] dat_addr,
  input  logic [7:0]    dat_wdata,
  output logic          dat_done,
  output logic [7:0]    dat_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ready
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [7:0]    slot [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt, cnt_n;
  logic          busy, is_data, drop;
  logic [AW-1:0] fetch_pc, next_fa, target;
  logic          flush, done, push, pop, boundary, go_data, go_fetch;

  assign flush     = redir_valid | irq_take;
  assign target    = irq_take ? irq_vector : redir_addr;
  assign done      = busy & mem_ready;
  assign push      = done & ~is_data & ~drop & ~flush;
  assign ins_valid = (cnt != '0);
  assign pop       = ins_valid & ins_ready & ~flush;
  assign boundary  = ~busy | mem_ready;
  assign cnt_n     = flush ? '0 : cnt + CW'(push) - CW'(pop);
  assign go_data   = dat_req & ~(done & is_data);
  assign go_fetch  = cnt_n < CW'(DEPTH);
  assign next_fa   = flush ? target : fetch_pc;
  assign ins_byte  = slot[rd_ptr];
  assign mem_req   = busy;
  assign dat_done  = done & is_data;
  assign dat_rdata = mem_rdata;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      ins_pc    <= RESET_PC;
      fetch_pc  <= RESET_PC;
      busy      <= 1'b0;
      is_data   <= 1'b0;
      drop      <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      cnt <= cnt_n;
      if (flush) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
        ins_pc <= target;
      end else begin
        if (push) wr_ptr <= bump(wr_ptr);
        if (pop) begin
          rd_ptr <= bump(rd_ptr);
          ins_pc <= ins_pc + 1'b1;
        end
      end
      if (boundary) begin
        drop <= 1'b0;
        if (go_data) begin
          busy      <= 1'b1;
          is_data   <= 1'b1;
          mem_we    <= dat_we;
          mem_addr  <= dat_addr;
          mem_wdata <= dat_wdata;
          fetch_pc  <= next_fa;
        end else if (go_fetch) begin
          busy     <= 1'b1;
          is_data  <= 1'b0;
          mem_we   <= 1'b0;
          mem_addr <= next_fa;
          fetch_pc <= next_fa + 1'b1;
        end else begin
          busy     <= 1'b0;
          is_data  <= 1'b0;
          mem_we   <= 1'b0;
          fetch_pc <= next_fa;
        end
      end else if (flush) begin
        fetch_pc <= target;
        if (!is_data) drop <= 1'b1;
      end
    end
  end
endmodule

module pfq_checker #(
  parameter int DEPTH = 4,
  parameter int AW = 16,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          ins_valid,
  input logic          ins_ready,
  input logic [AW-1:0] ins_pc,
  input logic          redir_valid,
  input logic          irq_take,
  input logic [AW-1:0] irq_vector,
  input logic          dat_req,
  input logic          dat_done,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata
);
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid || irq_take) |=> !ins_valid);

  assert_irq_vector_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> ins_pc == $past(irq_vector));

  assert_done_in_transfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dat_done |-> (dat_req && mem_req && mem_ready));

  assert_hold_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_pc_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && !redir_valid && !irq_take) |=> (ins_pc - $past(ins_pc)) == AW'(1));
endmodule

bind prefetch_queue_unit pfq_checker #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_pfq_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .ins_pc(ins_pc), .redir_valid(redir_valid), .irq_take(irq_take), .irq_vector(irq_vector),
  .dat_req(dat_req), .dat_done(dat_done), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/tb_prefetch_queue_unit.sv
module tb_prefetch_queue_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam logic [15:0] RST_PC = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid, ins_ready = 1'b0;
  logic [7:0] ins_byte;
  logic [15:0] ins_pc;
  logic redir_valid = 1'b0, irq_take = 1'b0;
  logic [15:0] redir_addr = '0, irq_vector = '0;
  logic dat_req = 1'b0, dat_we = 1'b0;
  logic [15:0] dat_addr = '0;
  logic [7:0] dat_wdata = '0;
  logic dat_done;
  logic [7:0] dat_rdata;
  logic mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic mem_ready = 1'b0;

  int n_cmp = 0, n_bad = 0, wait_pct = 0;
  bit run_cmp = 1'b0;
  logic [7:0] wmem [int];

  logic [7:0] mq [$];
  logic [15:0] mpc, mfpc, maddr;
  logic [7:0] mwd;
  bit mbusy, mdata, mdrop, mwe;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefetch_queue_unit #(.DEPTH(DEPTH), .AW(16), .RESET_PC(RST_PC)) dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_byte(ins_byte), .ins_pc(ins_pc),
    .ins_ready(ins_ready), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .irq_take(irq_take), .irq_vector(irq_vector), .dat_req(dat_req), .dat_we(dat_we),
    .dat_addr(dat_addr), .dat_wdata(dat_wdata), .dat_done(dat_done), .dat_rdata(dat_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  function automatic logic [7:0] memrd(input logic [15:0] a);
    if (wmem.exists(int'(a))) return wmem[int'(a)];
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5a;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Behavioural reference: byte queue plus bus-cycle bookkeeping
  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      mpc = RST_PC; mfpc = RST_PC; maddr = '0; mwd = '0;
      mbusy = 0; mdata = 0; mdrop = 0; mwe = 0;
    end else begin
      bit fl, dn, pp;
      logic [15:0] tg, nf;
      fl = redir_valid || irq_take;
      tg = irq_take ? irq_vector : redir_addr;
      dn = mbusy && mem_ready;
      pp = (mq.size() != 0) && ins_ready && !fl;
      if (fl) mq.delete();
      else begin
        if (pp) void'(mq.pop_front());
        if (dn && !mdata && !mdrop) mq.push_back(memrd(maddr));
      end
      mpc = fl ? tg : mpc + 16'(pp);
      if (!mbusy || mem_ready) begin
        mdrop = 0;
        nf = fl ? tg : mfpc;
        if (dat_req && !(dn && mdata)) begin
          mbusy = 1; mdata = 1; maddr = dat_addr; mwe = dat_we; mwd = dat_wdata; mfpc = nf;
        end else if (mq.size() < DEPTH) begin
          mbusy = 1; mdata = 0; maddr = nf; mwe = 0; mfpc = nf + 16'd1;
        end else begin
          mbusy = 0; mdata = 0; mwe = 0; mfpc = nf;
        end
      end else if (fl) begin
        mfpc = tg;
        if (!mdata) mdrop = 1;
      end
    end
  end

  // Per-cycle comparison, then the memory side of the bus
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk("R3", 32'(ins_valid), 32'(mq.size() != 0), "ins_valid");
      if (mq.size() != 0) chk("R3", 32'(ins_byte), 32'(mq[0]), "ins_byte");
      chk("R10", 32'(ins_pc), 32'(mpc), "ins_pc");
      chk("R7", 32'(mem_req), 32'(mbusy), "mem_req");
      if (mbusy) begin
        chk("R2", 32'(mem_addr), 32'(maddr), "mem_addr");
        chk("R8", 32'(mem_we), 32'(mwe), "mem_we");
        if (mwe) chk("R8", 32'(mem_wdata), 32'(mwd), "mem_wdata");
      end
    end
    #2;
    mem_ready = (int'($urandom_range(99)) >= wait_pct);
    mem_rdata = memrd(mem_addr);
    if (rst_n && mem_req && mem_we && mem_ready) wmem[int'(mem_addr)] = mem_wdata;
  end

  task automatic do_data(input bit we, input logic [15:0] a, input logic [7:0] wd);
    logic [7:0] exp;
    exp = memrd(a);
    @(negedge clk);
    dat_req = 1; dat_we = we; dat_addr = a; dat_wdata = wd;
    forever begin
      @(negedge clk);
      #3;
      if (dat_done) break;
    end
    if (!we) chk("R8", 32'(dat_rdata), 32'(exp), "dat_rdata");
    @(negedge clk);
    dat_req = 0;
  endtask

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    chk("R10", 32'(ins_pc), 32'(RST_PC), "reset ins_pc");
    chk("R3", 32'(ins_valid), 0, "reset ins_valid");
    chk("R12", 32'(mem_req), 0, "reset mem_req");
    rst_n = 1; run_cmp = 1;
    @(negedge clk);
    chk("R2", 32'(mem_req), 1, "first fetch req");
    chk("R2", 32'(mem_addr), 32'(RST_PC), "first fetch addr");
    repeat (10) @(negedge clk);
    chk("R1", 32'(mem_req), 0, "bus idle when full");
    chk("R3", 32'(ins_byte), 32'(memrd(RST_PC)), "head byte");

    redir_valid = 1; redir_addr = 16'h1234;
    @(negedge clk);
    redir_valid = 0;
    chk("R4", 32'(ins_valid), 0, "flushed");
    chk("R10", 32'(ins_pc), 32'h1234, "pc at target");
    chk("R4", 32'(mem_addr), 32'h1234, "fetch at target");
    @(negedge clk);
    chk("R11", 32'(ins_valid), 1, "target byte arrives");
    chk("R11", 32'(ins_byte), 32'(memrd(16'h1234)), "target byte");

    wait_pct = 100;
    @(negedge clk);
    held = mem_addr;
    chk("R9", 32'(mem_req), 1, "fetch stalled");
    redir_valid = 1; redir_addr = 16'h2000;
    @(negedge clk);
    redir_valid = 0;
    chk("R9", 32'(mem_addr), 32'(held), "addr held in wait");
    chk("R6", 32'(ins_valid), 0, "flush during fetch");
    wait_pct = 0;
    @(negedge clk);
    chk("R6", 32'(ins_valid), 0, "stale byte dropped");
    chk("R6", 32'(mem_addr), 32'h2000, "refetch target");
    @(negedge clk);
    chk("R11", 32'(ins_byte), 32'(memrd(16'h2000)), "new target byte");

    redir_valid = 1; redir_addr = 16'h3000; irq_take = 1; irq_vector = 16'h0080;
    @(negedge clk);
    redir_valid = 0; irq_take = 0;
    chk("R5", 32'(ins_pc), 32'h0080, "irq wins pc");
    chk("R5", 32'(mem_addr), 32'h0080, "irq wins fetch");

    wait_pct = 100;
    @(negedge clk);
    held = mem_addr;
    dat_req = 1; dat_we = 0; dat_addr = 16'h4000;
    @(negedge clk);
    chk("R7", 32'(mem_addr), 32'(held), "no grant mid-fetch");
    wait_pct = 0;
    @(negedge clk);
    chk("R7", 32'(mem_addr), 32'h4000, "grant at boundary");
    #3;
    chk("R8", 32'(dat_done), 1, "dat_done");
    chk("R8", 32'(dat_rdata), 32'(memrd(16'h4000)), "load data");
    @(negedge clk);
    dat_req = 0;

    do_data(1, 16'h5000, 8'hC3);
    @(negedge clk);
    redir_valid = 1; redir_addr = 16'h5000;
    @(negedge clk);
    redir_valid = 0;
    @(negedge clk);
    chk("R8", 32'(ins_byte), 32'h00C3, "stored byte fetched");

    redir_valid = 1; redir_addr = 16'hFFFE;
    @(negedge clk);
    redir_valid = 0;

    for (int ph = 0; ph < 3; ph++) begin
      wait_pct = (ph == 0) ? 0 : (ph == 1) ? 30 : 70;
      for (int c = 0; c < 1500; c++) begin
        @(negedge clk);
        ins_ready = ($urandom_range(3) != 0);
        redir_valid = ($urandom_range(49) == 0);
        redir_addr = ($urandom_range(3) == 0) ? 16'hFFFD : 16'($urandom_range(16'hFFFF));
        irq_take = ($urandom_range(119) == 0);
        irq_vector = 16'h0040 + 16'($urandom_range(7));
        if ($urandom_range(59) == 0) begin
          redir_valid = 0; irq_take = 0;
          do_data(1'($urandom_range(1)), 16'h5000 + 16'($urandom_range(15)), 8'($urandom_range(255)));
        end
      end
    end
    @(negedge clk);
    redir_valid = 0; irq_take = 0;
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule